// File: doc/BRIEF.md
# Branch Target and Execution-State Unit

This block keeps the program counter and the execution-state flag of a core that only runs a compressed, halfword-aligned instruction set. Each cycle it either advances the PC past the current instruction, loads a branch target, or leaves the PC alone. It also writes a link value on calls.

A branch target carries the state bit in bit 0. Bits above bit 0 go to the PC, and bit 0 goes to the state flag. The core has only one instruction set, so a target with bit 0 clear raises a state fault instead of switching mode.

In handler mode, two reserved target values are not fetch addresses. They mark a return from an exception and select which stack the context is restored from. The block reports that marker and leaves the actual unstacking to other logic.

Top module: `pc_state_unit`

## Requirements
- R1: An accepted branch load writes target bits [ADDR_W-1:1] into the PC, and PC bit 0 always reads 0.
- R2: On an accepted branch load, target bit 0 (which is 1) is written to the state flag `state_q`, and the state flag never changes otherwise.
- R3: When `br_link` is set with an accepted load, `lr_q` takes the return address (PC plus the current instruction length) with bit 0 replaced by the current state flag, and `lr_wr` pulses for one cycle. At PC 0x08000654 with a 4-byte call, `lr_q` becomes 0x08000659. `lr_q` holds its value at all other times.
- R4: With `adv_en` high and no branch, the PC advances by 4 when `insn_wide` is 1 and by 2 when it is 0. With neither `adv_en` nor `br_valid`, the PC holds.
- R5: A branch target with bit 0 equal to 0 gives a one-cycle `state_fault` pulse. On that request the PC, the state flag and `lr_q` stay unchanged and `lr_wr` stays low.
- R6: With `handler_mode` high, a target of 0xFFFFFFF9 or 0xFFFFFFFD gives a one-cycle `exc_ret` pulse. On that request the PC stays unchanged and neither `state_fault` nor `lr_wr` is raised. With `handler_mode` low, these two values are ordinary branch targets.
- R7: `exc_ret_psp` is loaded on every exception-return request from target bit 2: 0 for 0xFFFFFFF9 (main stack) and 1 for 0xFFFFFFFD (process stack). It holds its value otherwise.
- R8: Priority within a cycle is reset, then exception return, then branch load, then sequential advance. A branch request suppresses the advance in the same cycle.
- R9: Reset (`rst_n` low) sets the state flag to 1 and loads the PC from `reset_vec` with bit 0 cleared. It also clears `lr_q`, `lr_wr`, `state_fault`, `exc_ret` and `exc_ret_psp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_vec | input | ADDR_W | Start address loaded at reset |
| adv_en | input | 1 | Step past the current instruction |
| insn_wide | input | 1 | Current instruction is 4 bytes (1) or 2 bytes (0) |
| br_valid | input | 1 | Branch request this cycle |
| br_link | input | 1 | The branch also writes the link value |
| br_target | input | ADDR_W | Branch target with the state bit in bit 0 |
| handler_mode | input | 1 | Core is running an exception handler |
| pc_q | output | ADDR_W | Program counter |
| state_q | output | 1 | Execution-state flag |
| lr_q | output | ADDR_W | Link value |
| lr_wr | output | 1 | Link value written this cycle |
| state_fault | output | 1 | Target with state bit clear was rejected |
| exc_ret | output | 1 | Exception-return marker detected |
| exc_ret_psp | output | 1 | Stack selected by the last marker: 1 process, 0 main |

## Verification
The bench runs the call example from the requirements to check the odd link value. A design that stored the raw return address would show an even `lr_q`. It then sends even targets. A design that loaded them would move the PC or clear the state flag instead of pulsing `state_fault`. Both marker values are sent in and out of handler mode, because a design that ignored the mode bit would turn an ordinary jump into an exception return. The bench also asserts `br_valid` and `adv_en` together, which would expose a wrong priority as a PC off by the instruction length.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [1:0] {
      TGT_LOAD   = 2'd0,
      TGT_FAULT  = 2'd1,
      TGT_EXCRET = 2'd2
   } tgt_kind_e;
endpackage

// File: rtl/pcs_target_classify.sv
module pcs_target_classify
   import pcs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit EXC_RET_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] target,
   input  logic              handler,
   output tgt_kind_e         kind,
   output logic              stack_psp
);
   localparam logic [ADDR_W-1:0] MARK_MAIN = {{(ADDR_W-4){1'b1}}, 4'b1001};
   localparam logic [ADDR_W-1:0] MARK_PROC = {{(ADDR_W-4){1'b1}}, 4'b1101};

   logic is_marker;

   generate
      if (EXC_RET_EN) begin : g_marker
         assign is_marker = handler && ((target == MARK_MAIN) || (target == MARK_PROC));
      end else begin : g_no_marker
         assign is_marker = 1'b0;
      end
   endgenerate

   always_comb begin
      if (is_marker)
         kind = TGT_EXCRET;
      else if (target[0])
         kind = TGT_LOAD;
      else
         kind = TGT_FAULT;
   end

   // bit 2 separates the two marker values
   assign stack_psp = target[2];
endmodule

// File: rtl/pcs_seq_step.sv
module pcs_seq_step #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic              wide,
   output logic [ADDR_W-1:0] next_pc
);
   localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(4);

   assign next_pc = pc + (wide ? STEP_WIDE : STEP_NARROW);
endmodule

// File: rtl/pc_state_unit.sv
module pc_state_unit
   import pcs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit EXC_RET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reset_vec,
   input  logic              adv_en,
   input  logic              insn_wide,
   input  logic              br_valid,
   input  logic              br_link,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              handler_mode,
   output logic [ADDR_W-1:0] pc_q,
   output logic              state_q,
   output logic [ADDR_W-1:0] lr_q,
   output logic              lr_wr,
   output logic              state_fault,
   output logic              exc_ret,
   output logic              exc_ret_psp
);
   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
         $error("pc_state_unit: ADDR_W out of range 8..64");
      end
   endgenerate

   tgt_kind_e         kind;
   logic              sel_psp;
   logic [ADDR_W-1:0] seq_pc;

   pcs_target_classify #(
      .ADDR_W    (ADDR_W),
      .EXC_RET_EN(EXC_RET_EN)
   ) u_classify (
      .target   (br_target),
      .handler  (handler_mode),
      .kind     (kind),
      .stack_psp(sel_psp)
   );

   pcs_seq_step #(
      .ADDR_W(ADDR_W)
   ) u_step (
      .pc     (pc_q),
      .wide   (insn_wide),
      .next_pc(seq_pc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q        <= {reset_vec[ADDR_W-1:1], 1'b0};
         state_q     <= 1'b1;
         lr_q        <= '0;
         lr_wr       <= 1'b0;
         state_fault <= 1'b0;
         exc_ret     <= 1'b0;
         exc_ret_psp <= 1'b0;
      end else begin
         lr_wr       <= 1'b0;
         state_fault <= 1'b0;
         exc_ret     <= 1'b0;
         if (br_valid) begin
            unique case (kind)
               TGT_EXCRET: begin
                  exc_ret     <= 1'b1;
                  exc_ret_psp <= sel_psp;
               end
               TGT_FAULT: begin
                  state_fault <= 1'b1;
               end
               default: begin
                  pc_q    <= {br_target[ADDR_W-1:1], 1'b0};
                  state_q <= br_target[0];
                  if (br_link) begin
                     lr_q  <= {seq_pc[ADDR_W-1:1], state_q};
                     lr_wr <= 1'b1;
                  end
               end
            endcase
         end else if (adv_en) begin
            pc_q <= seq_pc;
         end
      end
   end
endmodule

// File: rtl/pc_state_unit_chk.sv
module pc_state_unit_chk #(
   parameter int ADDR_W     = 32,
   parameter bit EXC_RET_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv_en,
   input logic              insn_wide,
   input logic              br_valid,
   input logic [ADDR_W-1:0] br_target,
   input logic              handler_mode,
   input logic [ADDR_W-1:0] pc_q,
   input logic              state_q,
   input logic [ADDR_W-1:0] lr_q,
   input logic              lr_wr,
   input logic              state_fault,
   input logic              exc_ret,
   input logic              exc_ret_psp
);
   localparam logic [ADDR_W-1:0] M_MAIN = {{(ADDR_W-4){1'b1}}, 4'b1001};
   localparam logic [ADDR_W-1:0] M_PROC = {{(ADDR_W-4){1'b1}}, 4'b1101};
   localparam logic [ADDR_W-1:0] TWO    = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] FOUR   = ADDR_W'(4);

   logic mark;
   assign mark = EXC_RET_EN && handler_mode && (br_target == M_MAIN || br_target == M_PROC);

   // R1
   pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[0] == 1'b0);

   // R1
   branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_target[0] && !mark) |=> pc_q[ADDR_W-1:1] == $past(br_target[ADDR_W-1:1]));

   // R2
   state_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_target[0] && !mark) |=> state_q);

   // R3
   link_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lr_wr |-> lr_q[0] == $past(state_q));

   // R4
   seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !br_valid) |=> pc_q == ($past(insn_wide) ? $past(pc_q) + FOUR : $past(pc_q) + TWO));

   // R5
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_fault |-> ($stable(pc_q) && $stable(state_q) && $stable(lr_q) && !lr_wr));

   // R6
   excret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_ret |-> ($stable(pc_q) && !state_fault && !lr_wr));

   // R7
   stack_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_ret |-> exc_ret_psp == $past(br_target[2]));
endmodule

bind pc_state_unit pc_state_unit_chk #(
   .ADDR_W    (ADDR_W),
   .EXC_RET_EN(EXC_RET_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .adv_en      (adv_en),
   .insn_wide   (insn_wide),
   .br_valid    (br_valid),
   .br_target   (br_target),
   .handler_mode(handler_mode),
   .pc_q        (pc_q),
   .state_q     (state_q),
   .lr_q        (lr_q),
   .lr_wr       (lr_wr),
   .state_fault (state_fault),
   .exc_ret     (exc_ret),
   .exc_ret_psp (exc_ret_psp)
);

// File: tb/pc_state_unit_tb_top.sv
`timescale 1ns/1ps
module pc_state_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] reset_vec;
   logic        adv_en, insn_wide, br_valid, br_link, handler_mode;
   logic [31:0] br_target;
   logic [31:0] pc_q, lr_q;
   logic        state_q, lr_wr, state_fault, exc_ret, exc_ret_psp;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pc_state_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec),
      .adv_en(adv_en), .insn_wide(insn_wide),
      .br_valid(br_valid), .br_link(br_link), .br_target(br_target),
      .handler_mode(handler_mode),
      .pc_q(pc_q), .state_q(state_q), .lr_q(lr_q), .lr_wr(lr_wr),
      .state_fault(state_fault), .exc_ret(exc_ret), .exc_ret_psp(exc_ret_psp)
   );

   // behavioural reference model
   logic [31:0] m_pc, m_lr;
   logic        m_st, m_lrwr, m_flt, m_er, m_psp;
   wire  [31:0] m_next = m_pc + (insn_wide ? 32'd4 : 32'd2);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pc <= reset_vec & 32'hFFFF_FFFE;
         m_st <= 1'b1; m_lr <= 32'd0;
         m_lrwr <= 0; m_flt <= 0; m_er <= 0; m_psp <= 0;
      end else begin
         m_lrwr <= 0; m_flt <= 0; m_er <= 0;
         if (br_valid) begin
            if (handler_mode && (br_target == 32'hFFFF_FFF9 || br_target == 32'hFFFF_FFFD)) begin
               m_er  <= 1;
               m_psp <= (br_target == 32'hFFFF_FFFD);
            end else if (br_target[0] == 1'b0) begin
               m_flt <= 1;
            end else begin
               m_pc <= br_target & 32'hFFFF_FFFE;
               m_st <= 1'b1;
               if (br_link) begin
                  m_lr   <= m_next | {31'd0, m_st};
                  m_lrwr <= 1;
               end
            end
         end else if (adv_en) begin
            m_pc <= m_next;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         chk("R1 pc", pc_q, m_pc);
         chk("R2 state", {31'd0, state_q}, {31'd0, m_st});
         chk("R3 lr", lr_q, m_lr);
         chk("R3 lr_wr", {31'd0, lr_wr}, {31'd0, m_lrwr});
         chk("R5 fault", {31'd0, state_fault}, {31'd0, m_flt});
         chk("R6 exc_ret", {31'd0, exc_ret}, {31'd0, m_er});
         chk("R7 psp", {31'd0, exc_ret_psp}, {31'd0, m_psp});
      end
   end

   task automatic drive(bit adv, bit wide, bit bv, bit bl, logic [31:0] tgt, bit hm);
      adv_en = adv; insn_wide = wide; br_valid = bv; br_link = bl;
      br_target = tgt; handler_mode = hm;
      @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      rst_n = 0; reset_vec = 32'h0800_0655;
      adv_en = 0; insn_wide = 0; br_valid = 0; br_link = 0;
      br_target = 32'd0; handler_mode = 0;
      repeat (3) @(negedge clk);
      #1;
      // R9 reset state
      chk("R9 pc", pc_q, 32'h0800_0654);
      chk("R9 state", {31'd0, state_q}, 32'd1);
      chk("R9 lr", lr_q, 32'd0);
      chk("R9 pulses", {28'd0, lr_wr, state_fault, exc_ret, exc_ret_psp}, 32'd0);
      rst_n = 1;

      // R3 call with 4-byte instruction at 0x08000654
      drive(0, 1, 1, 1, 32'h0800_05DD, 0);
      chk("R1 load", pc_q, 32'h0800_05DC);
      chk("R3 link odd", lr_q, 32'h0800_0659);
      chk("R3 lr_wr", {31'd0, lr_wr}, 32'd1);
      // R4 advance
      drive(1, 0, 0, 0, 32'd0, 0);
      chk("R4 +2", pc_q, 32'h0800_05DE);
      chk("R3 lr_wr pulse", {31'd0, lr_wr}, 32'd0);
      drive(1, 1, 0, 0, 32'd0, 0);
      chk("R4 +4", pc_q, 32'h0800_05E2);
      drive(0, 1, 0, 0, 32'd0, 0);
      chk("R4 hold", pc_q, 32'h0800_05E2);
      // R5 even target
      drive(0, 0, 1, 1, 32'h0800_0700, 0);
      chk("R5 fault", {31'd0, state_fault}, 32'd1);
      chk("R5 pc kept", pc_q, 32'h0800_05E2);
      chk("R5 lr kept", lr_q, 32'h0800_0659);
      chk("R5 no link", {31'd0, lr_wr}, 32'd0);
      drive(0, 0, 0, 0, 32'd0, 0);
      chk("R5 pulse", {31'd0, state_fault}, 32'd0);
      // R8 branch wins over advance
      drive(1, 1, 1, 0, 32'h0800_0659, 0);
      chk("R8 priority", pc_q, 32'h0800_0658);
      // R6 R7 markers in handler mode
      drive(1, 0, 1, 0, 32'hFFFF_FFF9, 1);
      chk("R6 exc_ret", {31'd0, exc_ret}, 32'd1);
      chk("R6 pc kept", pc_q, 32'h0800_0658);
      chk("R7 main", {31'd0, exc_ret_psp}, 32'd0);
      drive(0, 0, 1, 1, 32'hFFFF_FFFD, 1);
      chk("R7 process", {31'd0, exc_ret_psp}, 32'd1);
      chk("R6 no link", {31'd0, lr_wr}, 32'd0);
      drive(0, 0, 0, 0, 32'd0, 1);
      chk("R6 pulse", {31'd0, exc_ret}, 32'd0);
      chk("R7 held", {31'd0, exc_ret_psp}, 32'd1);
      // R6 outside handler mode the marker is an address
      drive(0, 0, 1, 0, 32'hFFFF_FFFD, 0);
      chk("R6 thread load", pc_q, 32'hFFFF_FFFC);
      chk("R6 no marker", {31'd0, exc_ret}, 32'd0);

      // random traffic, model compared every cycle
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] t;
         int r;
         r = $urandom % 8;
         t = $urandom;
         if (r == 0) t = 32'hFFFF_FFF9;
         else if (r == 1) t = 32'hFFFF_FFFD;
         else if (r < 4) t[0] = 1'b0;
         else t[0] = 1'b1;
         drive(($urandom % 3) != 0, $urandom % 2, ($urandom % 3) == 0,
               $urandom % 2, t, $urandom % 2);
      end
      finish_run();
   end
endmodule